// File: doc/BRIEF.md
# Two-Register Stack Processor Core

This block is a compact stack-style processor that runs a fixed program held in a small internal program store. A program counter addresses the store. An instruction register holds the word being executed. Two data registers, top-of-stack (T) and next-of-stack (N), feed a function unit. A multiplexer picks what loads T: the function-unit result or the 8-bit switch input. A display register captures T on request. It is the whole execution engine of a small demonstration system. The display driver, clock divider and button debouncer sit outside it.

A three-state controller runs the fetch/execute sequence. An instruction without an operand executes in the same cycle that the following word is fetched, so straight-line code retires one instruction per clock. An opcode with bit 8 set owns the next word as its jump target and takes a dedicated execute cycle. Two conditional jumps test the level of the button input.

Top module: `spc_core`

## Requirements
- R1: While `rst_n` is low, T, N, the display register, the program counter and the instruction register are 0 and the controller is in its fetch state. After `rst_n` rises, a two-flop synchronizer delays release, and the third rising edge after the release performs the first fetch, from address 0.
- R2: From the fetch or the overlapped execute-fetch state, the next state is the execute-only state when bit 8 of the word read from the store is 1, and the overlapped state when it is 0. The execute-only state is always followed by the fetch state.
- R3: The instruction register loads in the fetch and overlapped states. It executes in the execute-only and overlapped states. The program counter increments by one in every state unless a jump takes over.
- R4: Opcode 0x0037 loads T with the switch value zero-extended to 16 bits.
- R5: Opcode 0x0018 loads T with T shifted left by one. The low 6 bits of the instruction register are the function-unit select, and T wraps modulo 2^16.
- R6: Opcode 0x0001 copies T into N. Opcode 0x0010 loads T with T+N modulo 2^16. N changes on no other opcode.
- R7: Opcode 0x0038 loads the display register from T. The display register holds its value on every other cycle.
- R8: Opcode 0x0101 loads the program counter with the following word and does not increment.
- R9: Opcode 0x010D jumps to the following word when the button is 1 and skips the operand when it is 0. Opcode 0x0109 jumps when the button is 0 and skips when it is 1.
- R10: Any other opcode changes neither T, N nor the display register. The program counter still advances, and an unknown opcode with bit 8 set also skips one operand word.
- R11: The store holds, from address 0: 0x0037, 0x0018, 0x0001, 0x0018, 0x0018, 0x0010, 0x0038, 0x010D, 0x000B, 0x0018, 0x0038, 0x0109, 0x0000, 0x0100, 0x0000, 0x00FF, 0x0018, 0x0038, 0x010D, 0x0010, 0x0101, 0x0000. Every other address reads 0. With switches at 0x3B, the display first receives 0x024E.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low clear, released synchronously inside |
| sw_in | input | 8 | Switch value read by the switch-load opcode |
| btn_in | input | 1 | Button level tested by the conditional jumps |
| disp_q | output | 16 | Display register |
| tos_q | output | 16 | Current top-of-stack value |

## Verification
The assertions watch the controller on every cycle. They check that the execute-only state always returns to fetch, that a word with bit 8 set always leads to the execute-only state, and that jumps load or skip the operand according to the button. They also check that N and the display register move only on their own opcodes, that the switch load is zero-extended, and that unknown opcodes leave T untouched. The actual program flow needs the bench's scenarios and its clock-by-clock model: the first display value of 0x024E, the two branch paths, the doubling loop wrapping T to zero while the button is held, the unconditional jump back to start, and a clear applied mid-run.

// File: rtl/spc_pkg.sv
package spc_pkg;

  localparam int IW       = 16;
  localparam int OPND_BIT = 8;

  localparam logic [IW-1:0] OP_DUP     = 16'h0001;
  localparam logic [IW-1:0] OP_ADD     = 16'h0010;
  localparam logic [IW-1:0] OP_DBL     = 16'h0018;
  localparam logic [IW-1:0] OP_SWIN    = 16'h0037;
  localparam logic [IW-1:0] OP_SHOW    = 16'h0038;
  localparam logic [IW-1:0] OP_JMP     = 16'h0101;
  localparam logic [IW-1:0] OP_JBTN_LO = 16'h0109;
  localparam logic [IW-1:0] OP_JBTN_HI = 16'h010D;

  localparam logic [5:0] FS_ADD = 6'h10;
  localparam logic [5:0] FS_DBL = 6'h18;

  localparam logic [1:0] MSEL_FU = 2'b00;
  localparam logic [1:0] MSEL_SW = 2'b01;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_EXEC  = 2'd1,
    ST_EXF   = 2'd2
  } ctl_st_e;

  // Fixed program image; unlisted addresses read zero.
  function automatic logic [IW-1:0] prog_word(input logic [IW-1:0] addr);
    logic [IW-1:0] w;
    case (addr)
      16'd0:   w = OP_SWIN;
      16'd1:   w = OP_DBL;
      16'd2:   w = OP_DUP;
      16'd3:   w = OP_DBL;
      16'd4:   w = OP_DBL;
      16'd5:   w = OP_ADD;
      16'd6:   w = OP_SHOW;
      16'd7:   w = OP_JBTN_HI;
      16'd8:   w = 16'h000B;
      16'd9:   w = OP_DBL;
      16'd10:  w = OP_SHOW;
      16'd11:  w = OP_JBTN_LO;
      16'd12:  w = 16'h0000;
      16'd13:  w = 16'h0100;
      16'd14:  w = 16'h0000;
      16'd15:  w = 16'h00FF;
      16'd16:  w = OP_DBL;
      16'd17:  w = OP_SHOW;
      16'd18:  w = OP_JBTN_HI;
      16'd19:  w = 16'h0010;
      16'd20:  w = OP_JMP;
      16'd21:  w = 16'h0000;
      default: w = '0;
    endcase
    return w;
  endfunction

  function automatic logic op_known(input logic [IW-1:0] op);
    return (op == OP_DUP) || (op == OP_ADD) || (op == OP_DBL) ||
           (op == OP_SWIN) || (op == OP_SHOW) || (op == OP_JMP) ||
           (op == OP_JBTN_LO) || (op == OP_JBTN_HI);
  endfunction

endpackage

// File: rtl/spc_rst_sync.sv
module spc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/spc_fetch.sv
module spc_fetch #(
  parameter int PROG_DEPTH = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   iload,
  input  logic                   pload,
  input  logic                   pinc,
  output logic [spc_pkg::IW-1:0] pc_q,
  output logic [spc_pkg::IW-1:0] ir_q,
  output logic [spc_pkg::IW-1:0] rom_word
);
  import spc_pkg::*;

  localparam logic [IW-1:0] DEPTH_W = IW'(PROG_DEPTH);

  logic [IW-1:0] pc_d;
  logic          pc_en;

  // Program store read, combinational on the current PC
  always_comb begin
    if (pc_q < DEPTH_W) begin
      rom_word = prog_word(pc_q);
    end else begin
      rom_word = '0;
    end
  end

  always_comb begin
    pc_en = pload | pinc;
    if (pload) begin
      pc_d = rom_word;
    end else begin
      pc_d = pc_q + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q <= '0;
    end else if (iload) begin
      ir_q <= rom_word;
    end
  end

endmodule

// File: rtl/spc_ctrl.sv
module spc_ctrl (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [spc_pkg::IW-1:0] ir_q,
  input  logic                   opnd_flag,
  input  logic                   btn,
  output spc_pkg::ctl_st_e       st_q,
  output logic                   iload,
  output logic                   pload,
  output logic                   pinc,
  output logic                   tload,
  output logic                   nload,
  output logic                   dload,
  output logic [1:0]             msel,
  output logic [5:0]             fsel
);
  import spc_pkg::*;

  ctl_st_e st_d;
  logic    exe;

  // Next-state logic
  always_comb begin
    case (st_q)
      ST_FETCH, ST_EXF: st_d = opnd_flag ? ST_EXEC : ST_EXF;
      ST_EXEC:          st_d = ST_FETCH;
      default:          st_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_FETCH;
    end else begin
      st_q <= st_d;
    end
  end

  // Decode of the held instruction
  always_comb begin
    iload = (st_q == ST_FETCH) || (st_q == ST_EXF);
    exe   = (st_q == ST_EXEC) || (st_q == ST_EXF);
    pinc  = 1'b1;
    pload = 1'b0;
    tload = 1'b0;
    nload = 1'b0;
    dload = 1'b0;
    msel  = MSEL_FU;
    fsel  = ir_q[5:0];
    if (exe) begin
      case (ir_q)
        OP_DUP:  nload = 1'b1;
        OP_ADD:  tload = 1'b1;
        OP_DBL:  tload = 1'b1;
        OP_SWIN: begin
          tload = 1'b1;
          msel  = MSEL_SW;
        end
        OP_SHOW: dload = 1'b1;
        OP_JMP: begin
          pload = 1'b1;
          pinc  = 1'b0;
        end
        OP_JBTN_LO: begin
          pload = ~btn;
          pinc  = btn;
        end
        OP_JBTN_HI: begin
          pload = btn;
          pinc  = ~btn;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/spc_datapath.sv
module spc_datapath #(
  parameter int DW   = 16,
  parameter int SW_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tload,
  input  logic            nload,
  input  logic            dload,
  input  logic [1:0]      msel,
  input  logic [5:0]      fsel,
  input  logic [SW_W-1:0] sw,
  output logic [DW-1:0]   tos_q,
  output logic [DW-1:0]   nos_q,
  output logic [DW-1:0]   disp_q
);
  import spc_pkg::*;

  logic [DW-1:0] sw_ext;
  logic [DW-1:0] fu_out;
  logic [DW-1:0] tos_d;

  generate
    if (DW > SW_W) begin : g_zext
      assign sw_ext = {{(DW-SW_W){1'b0}}, sw};
    end else begin : g_trunc
      assign sw_ext = sw[DW-1:0];
    end
  endgenerate

  // Function unit
  always_comb begin
    case (fsel)
      FS_ADD:  fu_out = tos_q + nos_q;
      FS_DBL:  fu_out = {tos_q[DW-2:0], 1'b0};
      default: fu_out = tos_q;
    endcase
  end

  // T input multiplexer
  always_comb begin
    case (msel)
      MSEL_FU: tos_d = fu_out;
      MSEL_SW: tos_d = sw_ext;
      default: tos_d = tos_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tos_q <= '0;
    end else if (tload) begin
      tos_q <= tos_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nos_q <= '0;
    end else if (nload) begin
      nos_q <= tos_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_q <= '0;
    end else if (dload) begin
      disp_q <= tos_q;
    end
  end

endmodule

// File: rtl/spc_core.sv
module spc_core #(
  parameter int DW          = 16,
  parameter int SW_W        = 8,
  parameter int PROG_DEPTH  = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SW_W-1:0] sw_in,
  input  logic            btn_in,
  output logic [DW-1:0]   disp_q,
  output logic [DW-1:0]   tos_q
);
  import spc_pkg::*;

  logic          rst_sync_n;
  logic [IW-1:0] pc_q;
  logic [IW-1:0] ir_q;
  logic [IW-1:0] rom_word;
  logic [DW-1:0] nos_q;
  ctl_st_e       ctl_st;
  logic          iload, pload, pinc, tload, nload, dload;
  logic [1:0]    msel;
  logic [5:0]    fsel;

  spc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  spc_fetch #(.PROG_DEPTH(PROG_DEPTH)) u_fetch (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .iload    (iload),
    .pload    (pload),
    .pinc     (pinc),
    .pc_q     (pc_q),
    .ir_q     (ir_q),
    .rom_word (rom_word)
  );

  spc_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ir_q      (ir_q),
    .opnd_flag (rom_word[OPND_BIT]),
    .btn       (btn_in),
    .st_q      (ctl_st),
    .iload     (iload),
    .pload     (pload),
    .pinc      (pinc),
    .tload     (tload),
    .nload     (nload),
    .dload     (dload),
    .msel      (msel),
    .fsel      (fsel)
  );

  spc_datapath #(.DW(DW), .SW_W(SW_W)) u_dp (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tload  (tload),
    .nload  (nload),
    .dload  (dload),
    .msel   (msel),
    .fsel   (fsel),
    .sw     (sw_in),
    .tos_q  (tos_q),
    .nos_q  (nos_q),
    .disp_q (disp_q)
  );

endmodule

// File: rtl/spc_core_chk.sv
module spc_core_chk #(
  parameter int DW   = 16,
  parameter int SW_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input spc_pkg::ctl_st_e       st,
  input logic [spc_pkg::IW-1:0] pc,
  input logic [spc_pkg::IW-1:0] ir,
  input logic [spc_pkg::IW-1:0] mem_word,
  input logic [DW-1:0]          tos,
  input logic [DW-1:0]          nos,
  input logic [DW-1:0]          disp,
  input logic [SW_W-1:0]        sw,
  input logic                   btn
);
  import spc_pkg::*;

  logic exe;
  assign exe = (st != ST_FETCH);

  AST_EXEC_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_EXEC) |=> (st == ST_FETCH)); // R2

  AST_OPND_TO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    ((st != ST_EXEC) && mem_word[OPND_BIT]) |=> (st == ST_EXEC)); // R2

  AST_IR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_EXEC) |=> $stable(ir)); // R3

  AST_SWIN_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (exe && ir == OP_SWIN) |=> (tos == {{(DW-SW_W){1'b0}}, $past(sw)})); // R4

  AST_DUP_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (exe && ir == OP_DUP) |=> (nos == $past(tos))); // R6

  AST_NOS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(exe && ir == OP_DUP) |=> $stable(nos)); // R6

  AST_DISP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(exe && ir == OP_SHOW) |=> $stable(disp)); // R7

  AST_JMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_EXEC && ir == OP_JMP) |=> (pc == $past(mem_word))); // R8

  AST_BTN_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_EXEC && ((ir == OP_JBTN_HI && btn) || (ir == OP_JBTN_LO && !btn)))
    |=> (pc == $past(mem_word))); // R9

  AST_BTN_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_EXEC && ((ir == OP_JBTN_HI && !btn) || (ir == OP_JBTN_LO && btn)))
    |=> (pc == $past(pc) + 16'd1)); // R9

  AST_UNKNOWN_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (exe && !op_known(ir)) |=> $stable(tos)); // R10

endmodule

bind spc_core spc_core_chk #(.DW(DW), .SW_W(SW_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .st       (ctl_st),
  .pc       (pc_q),
  .ir       (ir_q),
  .mem_word (rom_word),
  .tos      (tos_q),
  .nos      (nos_q),
  .disp     (disp_q),
  .sw       (sw_in),
  .btn      (btn_in)
);

// File: tb/spc_core_tb.sv
`timescale 1ns/1ps
module spc_core_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  sw_in;
  logic        btn_in;
  logic [15:0] disp_q;
  logic [15:0] tos_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  spc_core dut_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .sw_in  (sw_in),
    .btn_in (btn_in),
    .disp_q (disp_q),
    .tos_q  (tos_q)
  );

  // Program image written from R11
  function automatic int img(input int a);
    int lst[22] = '{'h37, 'h18, 'h01, 'h18, 'h18, 'h10, 'h38, 'h10D, 'h0B, 'h18, 'h38,
                    'h109, 'h00, 'h100, 'h00, 'hFF, 'h18, 'h38, 'h10D, 'h10, 'h101, 'h00};
    if (a >= 0 && a < 22) return lst[a];
    return 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference: phase 0 fetch, 1 operand execute, 2 overlapped
  int          m_ph  = 0;
  int          m_rel = 0;
  int          m_pc  = 0;
  int          m_ir  = 0;
  logic [15:0] m_t   = '0;
  logic [15:0] m_n   = '0;
  logic [15:0] m_d   = '0;

  always @(posedge clk) begin
    int w;
    int npc;
    logic [15:0] nt, nn, nd;
    if (!rst_n) begin
      m_ph = 0; m_rel = 0; m_pc = 0; m_ir = 0;
      m_t = '0; m_n = '0; m_d = '0;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      w   = img(m_pc);
      npc = (m_pc + 1) % 65536;
      nt = m_t; nn = m_n; nd = m_d;
      if (m_ph != 0) begin
        case (m_ir)
          'h01:  nn = m_t;
          'h10:  nt = m_t + m_n;
          'h18:  nt = m_t << 1;
          'h37:  nt = {8'h00, sw_in};
          'h38:  nd = m_t;
          'h101: npc = w;
          'h10D: if (btn_in) npc = w;
          'h109: if (!btn_in) npc = w;
          default: ;
        endcase
      end
      if (m_ph == 1) begin
        m_ph = 0;
      end else begin
        m_ir = w;
        m_ph = ((w >> 8) & 1) != 0 ? 1 : 2;
      end
      m_pc = npc; m_t = nt; m_n = nn; m_d = nd;
    end
  end

  // Clock-by-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n !== 1'bx && !done) begin
      chk(tos_q === m_t, "R2 R3 model tos", tos_q, m_t);
      chk(disp_q === m_d, "R2 R3 model disp", disp_q, m_d);
    end
  end

  task automatic wait_disp(input logic [15:0] v, input int maxc, input string tag);
    bit hit = 1'b0;
    for (int i = 0; i < maxc && !hit; i++) begin
      @(negedge clk);
      if (disp_q === v) hit = 1'b1;
    end
    chk(hit, tag, disp_q, v);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n  = 1'b0;
    sw_in  = 8'h3B;
    btn_in = 1'b0;
    repeat (3) @(negedge clk);
    chk(tos_q == 16'h0, "R1 reset tos", tos_q, 16'h0);
    chk(disp_q == 16'h0, "R1 reset disp", disp_q, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(tos_q == 16'h0, "R1 sync release holds", tos_q, 16'h0);
    // First pass: 0x3B gives 0x24E on the display
    wait_disp(16'h024E, 40, "R11 R6 first display value");
    // Button low: fall through at the high-button jump, double, show
    wait_disp(16'h049C, 20, "R9 high-jump not taken R5 doubling");
    // Low-button jump back to start with new switch value
    sw_in = 8'hFF;
    wait_disp(16'h09F6, 60, "R9 low-jump taken R4 switch load");
    // Button held: skip to doubling loop through unknown opcodes until wrap
    btn_in = 1'b1;
    wait_disp(16'h13EC, 60, "R9 R10 path via unknown opcodes");
    wait_disp(16'h0000, 200, "R5 doubling wraps to zero");
    chk(tos_q == 16'h0, "R5 tos wrapped", tos_q, 16'h0);
    // Release button: leave loop through unconditional jump
    btn_in = 1'b0;
    wait_disp(16'h09F6, 60, "R8 jump back to start");
    sw_in = 8'h01;
    wait_disp(16'h000A, 60, "R11 R4 small switch value");
    // Clear mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(disp_q == 16'h0, "R1 mid-run clear disp", disp_q, 16'h0);
    chk(tos_q == 16'h0, "R1 mid-run clear tos", tos_q, 16'h0);
    rst_n = 1'b1;
    wait_disp(16'h000A, 40, "R1 restart from address 0");
    done = 1'b1;
    summary();
    $finish;
  end

endmodule